// File: doc/BRIEF.md
# Burst-to-Single Access Bridge

This block joins a high-throughput master port to a simple peripheral slave port on a synchronous point-to-point request/response interface. The master side carries bursts in which every beat brings its own command, address, write data and byte enables. A last-request flag frames each burst, and a response-accept handshake lets the master throttle responses. The slave side understands single accesses only. The bridge turns every master beat into one single slave access and passes each slave response back to the master. It rebuilds the last-response flag from the framing of the request that the response answers.

Only one slave access is in flight at a time. While a beat is being forwarded, while the slave has not answered, or while the master has not taken a response, the bridge holds off the master's command accept. The bridge never invents addresses, so incrementing, wrapping and constant address sequences all pass through unchanged. Posted writes finish as soon as the slave takes them and produce no upstream response. Reads and non-posted writes wait for the slave's response.

Top module: `burst_single_bridge`

## Requirements
- R1: After reset, dnCmd is idle (0), upResp is none (0), upRespLast is 0 and upCmdAccept is 1.
- R2: The command codes are: idle 0, posted write 1, read 2, non-posted write 5. Each upstream beat taken while upCmdAccept is 1 with one of the codes 1, 2 or 5 is presented on the downstream port from the next cycle. It is presented as exactly one access with the same command, address, data and byte enables. It is held stable until dnCmdAccept is 1. All other upCmd codes are treated as idle and produce no downstream access.
- R3: Beats of incrementing, wrapping and constant address sequences are all forwarded, in order, with the address each beat carried.
- R4: upCmdAccept is 0 from the cycle after a beat is taken until that access completes. A posted write completes when it is accepted downstream. A read or non-posted write completes when its upstream response is accepted.
- R5: A posted write produces no upstream response. upCmdAccept returns to 1 in the cycle after the slave accepts it.
- R6: For a read or non-posted write, the first nonzero dnResp seen while the access waits for a response, or in the cycle the slave accepts it, is presented on upResp and upRespData from the next cycle. The codes are: none 0, success 1, error 3.
- R7: upRespLast equals the upReqLast value of the request the response answers.
- R8: While upResp is nonzero and upRespAccept is 0, upResp, upRespData and upRespLast hold their values into the next cycle.
- R9: In a cycle where a response is accepted upstream, upCmdAccept is 1, so a new beat can be taken in that same cycle.
- R10: A nonzero dnResp while no access waits for a response is ignored: upResp stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upCmd | input | 3 | Upstream beat command |
| upAddr | input | ADDR_W | Upstream beat address |
| upData | input | DATA_W | Upstream beat write data |
| upByteEn | input | DATA_W/8 | Upstream beat byte enables |
| upReqLast | input | 1 | Marks the final request of a burst |
| upCmdAccept | output | 1 | Bridge takes the upstream beat this cycle |
| upResp | output | 2 | Upstream response code |
| upRespData | output | DATA_W | Upstream response data |
| upRespLast | output | 1 | Marks the final response of a burst |
| upRespAccept | input | 1 | Master takes the response this cycle |
| dnCmd | output | 3 | Downstream single-access command |
| dnAddr | output | ADDR_W | Downstream address |
| dnData | output | DATA_W | Downstream write data |
| dnByteEn | output | DATA_W/8 | Downstream byte enables |
| dnCmdAccept | input | 1 | Slave takes the downstream command |
| dnResp | input | 2 | Downstream response code |
| dnRespData | input | DATA_W | Downstream response data |

## Verification
Two overlaps matter. In one, the master retires a response in the same cycle as the bridge takes the next beat. In the other, the slave accepts a command and answers it in the same cycle. The bench provokes the first with a response-accept that is always high and back-to-back reads. It provokes the second with a slave that answers with zero delay. It judges both against a queue-based model that predicts upCmdAccept, upResp and dnCmd every cycle. It also counts that at least one retire-plus-take cycle was seen. Random accept stalls on both sides and random slave latency then mix these overlaps with ordinary stalled cycles.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

  localparam int CMD_W  = 3;
  localparam int RESP_W = 2;

  localparam logic [CMD_W-1:0] CMD_IDLE     = 3'd0;
  localparam logic [CMD_W-1:0] CMD_WRITE    = 3'd1;
  localparam logic [CMD_W-1:0] CMD_READ     = 3'd2;
  localparam logic [CMD_W-1:0] CMD_WRITE_NP = 3'd5;

  localparam logic [RESP_W-1:0] RESP_NONE = 2'd0;
  localparam logic [RESP_W-1:0] RESP_OK   = 2'd1;
  localparam logic [RESP_W-1:0] RESP_FAIL = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FWD,
    ST_WAIT,
    ST_RESP
  } bsbState_t;

  typedef struct packed {
    logic takeReq;
    logic dropReq;
    logic takeResp;
    logic dropResp;
  } bsbStrobes_t;

  function automatic logic isBeat(input logic [CMD_W-1:0] cmd);
    return (cmd == CMD_WRITE) || (cmd == CMD_READ) || (cmd == CMD_WRITE_NP);
  endfunction

endpackage

// File: rtl/bsb_ctrl.sv
module bsb_ctrl
  import bsb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  upCmd,
  input  logic              upRespAccept,
  input  logic              dnCmdAccept,
  input  logic [RESP_W-1:0] dnResp,
  input  logic              heldPosted,
  output logic              upCmdAccept,
  output bsbStrobes_t       strobes
);

  bsbState_t state, stateNext;
  logic      respArrives;
  logic      fwdDone;

  assign fwdDone     = (state == ST_FWD) && dnCmdAccept;
  assign respArrives = (dnResp != RESP_NONE) &&
                       ((state == ST_WAIT) || (fwdDone && !heldPosted));

  assign upCmdAccept = (state == ST_IDLE) || ((state == ST_RESP) && upRespAccept);

  always_comb begin
    strobes          = '0;
    strobes.takeReq  = upCmdAccept && isBeat(upCmd);
    strobes.dropReq  = fwdDone;
    strobes.takeResp = respArrives;
    strobes.dropResp = (state == ST_RESP) && upRespAccept;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobes.takeReq) stateNext = ST_FWD;
      ST_FWD: begin
        if (dnCmdAccept) begin
          if (heldPosted)       stateNext = ST_IDLE;
          else if (respArrives) stateNext = ST_RESP;
          else                  stateNext = ST_WAIT;
        end
      end
      ST_WAIT: if (respArrives) stateNext = ST_RESP;
      ST_RESP: begin
        if (upRespAccept) stateNext = strobes.takeReq ? ST_FWD : ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R2: codes outside the beat set leave an idle bridge idle
  p_ignore_bad_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !isBeat(upCmd)) |=> (state == ST_IDLE));

  // R5: a posted write never enters the response wait
  p_posted_no_wait_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fwdDone && heldPosted) |=> (state == ST_IDLE));

endmodule

// File: rtl/bsb_datapath.sv
module bsb_datapath
  import bsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  bsbStrobes_t         strobes,
  input  logic [CMD_W-1:0]    upCmd,
  input  logic [ADDR_W-1:0]   upAddr,
  input  logic [DATA_W-1:0]   upData,
  input  logic [DATA_W/8-1:0] upByteEn,
  input  logic                upReqLast,
  input  logic [RESP_W-1:0]   dnResp,
  input  logic [DATA_W-1:0]   dnRespData,
  output logic [CMD_W-1:0]    dnCmd,
  output logic [ADDR_W-1:0]   dnAddr,
  output logic [DATA_W-1:0]   dnData,
  output logic [DATA_W/8-1:0] dnByteEn,
  output logic [RESP_W-1:0]   upResp,
  output logic [DATA_W-1:0]   upRespData,
  output logic                upRespLast,
  output logic                heldPosted
);

  localparam int BE_W = DATA_W / 8;

  logic              reqValid;
  logic [CMD_W-1:0]  reqCmd;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqData;
  logic [BE_W-1:0]   reqBe;
  logic              reqLast;

  logic              respValid;
  logic [RESP_W-1:0] respCode;
  logic [DATA_W-1:0] respData;
  logic              respLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqCmd   <= CMD_IDLE;
      reqAddr  <= '0;
      reqData  <= '0;
      reqBe    <= '0;
      reqLast  <= 1'b0;
    end else if (strobes.takeReq) begin
      reqValid <= 1'b1;
      reqCmd   <= upCmd;
      reqAddr  <= upAddr;
      reqData  <= upData;
      reqBe    <= upByteEn;
      reqLast  <= upReqLast;
    end else if (strobes.dropReq) begin
      reqValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respCode  <= RESP_NONE;
      respData  <= '0;
      respLast  <= 1'b0;
    end else if (strobes.takeResp) begin
      respValid <= 1'b1;
      respCode  <= dnResp;
      respData  <= dnRespData;
      respLast  <= reqLast;
    end else if (strobes.dropResp) begin
      respValid <= 1'b0;
    end
  end

  assign dnCmd      = reqValid ? reqCmd : CMD_IDLE;
  assign dnAddr     = reqAddr;
  assign dnData     = reqData;
  assign dnByteEn   = reqBe;
  assign upResp     = respValid ? respCode : RESP_NONE;
  assign upRespData = respData;
  assign upRespLast = respValid && respLast;
  assign heldPosted = (reqCmd == CMD_WRITE);

  // R7: a newly presented response carries the framing of its request
  p_last_follows_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeResp |=> (upRespLast == $past(reqLast)));

endmodule

// File: rtl/burst_single_bridge.sv
module burst_single_bridge
  import bsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          upCmd,
  input  logic [ADDR_W-1:0]   upAddr,
  input  logic [DATA_W-1:0]   upData,
  input  logic [DATA_W/8-1:0] upByteEn,
  input  logic                upReqLast,
  output logic                upCmdAccept,
  output logic [1:0]          upResp,
  output logic [DATA_W-1:0]   upRespData,
  output logic                upRespLast,
  input  logic                upRespAccept,
  output logic [2:0]          dnCmd,
  output logic [ADDR_W-1:0]   dnAddr,
  output logic [DATA_W-1:0]   dnData,
  output logic [DATA_W/8-1:0] dnByteEn,
  input  logic                dnCmdAccept,
  input  logic [1:0]          dnResp,
  input  logic [DATA_W-1:0]   dnRespData
);

  bsbStrobes_t strobes;
  logic        heldPosted;

  bsb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .upCmd        (upCmd),
    .upRespAccept (upRespAccept),
    .dnCmdAccept  (dnCmdAccept),
    .dnResp       (dnResp),
    .heldPosted   (heldPosted),
    .upCmdAccept  (upCmdAccept),
    .strobes      (strobes)
  );

  bsb_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .upCmd      (upCmd),
    .upAddr     (upAddr),
    .upData     (upData),
    .upByteEn   (upByteEn),
    .upReqLast  (upReqLast),
    .dnResp     (dnResp),
    .dnRespData (dnRespData),
    .dnCmd      (dnCmd),
    .dnAddr     (dnAddr),
    .dnData     (dnData),
    .dnByteEn   (dnByteEn),
    .upResp     (upResp),
    .upRespData (upRespData),
    .upRespLast (upRespLast),
    .heldPosted (heldPosted)
  );

  // R2: a presented downstream access holds until the slave takes it
  p_req_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dnCmd != CMD_IDLE && !dnCmdAccept) |=>
      ($stable(dnCmd) && $stable(dnAddr) && $stable(dnData) && $stable(dnByteEn)));

  // R8: a presented upstream response holds until the master takes it
  p_resp_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (upResp != RESP_NONE && !upRespAccept) |=>
      ($stable(upResp) && $stable(upRespData) && $stable(upRespLast)));

  // R4: no new beat while a downstream access is pending
  p_single_outstanding_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dnCmd != CMD_IDLE) |-> !upCmdAccept);

  // R4: a forwarded access and an upstream response never coexist
  p_fwd_resp_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    (upResp != RESP_NONE) |-> (dnCmd == CMD_IDLE));

  // R5: an accepted posted write leaves no upstream response behind
  p_posted_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dnCmd == CMD_WRITE && dnCmdAccept) |=> (upResp == RESP_NONE && upCmdAccept));

  // R9: a retired response always opens the command accept
  p_retire_opens_r9: assert property (@(posedge clk) disable iff (!rstN)
    (upResp != RESP_NONE && upRespAccept) |-> upCmdAccept);

endmodule

// File: tb/sim_burst_single_bridge.sv
`timescale 1ns/1ps
module sim_burst_single_bridge;
  import bsb_pkg::*;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]    upCmd = '0;
  logic [AW-1:0] upAddr = '0;
  logic [DW-1:0] upData = '0;
  logic [BW-1:0] upByteEn = '0;
  logic          upReqLast = 1'b0;
  logic          upCmdAccept;
  logic [1:0]    upResp;
  logic [DW-1:0] upRespData;
  logic          upRespLast;
  logic          upRespAccept = 1'b0;
  logic [2:0]    dnCmd;
  logic [AW-1:0] dnAddr;
  logic [DW-1:0] dnData;
  logic [BW-1:0] dnByteEn;
  logic          dnCmdAccept = 1'b0;
  logic [1:0]    dnResp = '0;
  logic [DW-1:0] dnRespData = '0;

  burst_single_bridge #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN),
    .upCmd(upCmd), .upAddr(upAddr), .upData(upData), .upByteEn(upByteEn),
    .upReqLast(upReqLast), .upCmdAccept(upCmdAccept),
    .upResp(upResp), .upRespData(upRespData), .upRespLast(upRespLast),
    .upRespAccept(upRespAccept),
    .dnCmd(dnCmd), .dnAddr(dnAddr), .dnData(dnData), .dnByteEn(dnByteEn),
    .dnCmdAccept(dnCmdAccept), .dnResp(dnResp), .dnRespData(dnRespData)
  );

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    logic [2:0]    cmd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [BW-1:0] be;
    logic          last;
  } beat_t;
  typedef struct {
    logic [1:0]    code;
    logic [DW-1:0] data;
    logic          last;
  } rsp_t;

  beat_t fwdQ[$];
  beat_t awaitQ[$];
  rsp_t  respQ[$];

  function automatic bit modelAccept(input bit ra);
    return (fwdQ.size() + awaitQ.size() + respQ.size() == 0) ||
           (respQ.size() != 0 && ra);
  endfunction

  always @(posedge clk or negedge rstN) begin
    beat_t f;
    beat_t nb;
    rsp_t  r;
    bit accNow, popResp, fromWait, fwdDone;
    if (!rstN) begin
      fwdQ.delete(); awaitQ.delete(); respQ.delete();
    end else begin
      accNow   = modelAccept(upRespAccept);
      popResp  = (respQ.size() != 0) && upRespAccept;
      fromWait = (awaitQ.size() != 0) && (dnResp != 2'd0);
      fwdDone  = (fwdQ.size() != 0) && dnCmdAccept;
      if (popResp) void'(respQ.pop_front());
      if (fromWait) begin
        f = awaitQ.pop_front();
        r.code = dnResp; r.data = dnRespData; r.last = f.last;
        respQ.push_back(r);
      end
      if (fwdDone) begin
        f = fwdQ.pop_front();
        if (f.cmd != 3'd1) begin
          if (dnResp != 2'd0) begin
            r.code = dnResp; r.data = dnRespData; r.last = f.last;
            respQ.push_back(r);
          end else begin
            awaitQ.push_back(f);
          end
        end
      end
      if (accNow && (upCmd == 3'd1 || upCmd == 3'd2 || upCmd == 3'd5)) begin
        nb.cmd = upCmd; nb.addr = upAddr; nb.data = upData;
        nb.be = upByteEn; nb.last = upReqLast;
        fwdQ.push_back(nb);
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  logic [1:0]    prevResp = '0;
  logic [DW-1:0] prevData = '0;
  logic          prevLast = 1'b0;
  logic          prevRa = 1'b0;
  bit            prevValid = 1'b0;
  int            respCount = 0;
  int            overlapCount = 0;
  logic [AW-1:0] dnLog[$];

  always @(negedge clk) begin
    logic [2:0] expCmd;
    logic [1:0] expResp;
    #2;
    if (rstN) begin
      expCmd = (fwdQ.size() != 0) ? fwdQ[0].cmd : 3'd0;
      check(dnCmd === expCmd, "R2", "dnCmd", 64'(dnCmd), 64'(expCmd));
      if (fwdQ.size() != 0) begin
        check(dnAddr === fwdQ[0].addr, "R2", "dnAddr", 64'(dnAddr), 64'(fwdQ[0].addr));
        check(dnData === fwdQ[0].data && dnByteEn === fwdQ[0].be, "R2", "dnData/be",
              {dnByteEn, dnData}, {fwdQ[0].be, fwdQ[0].data});
      end
      check(upCmdAccept === modelAccept(upRespAccept), "R4", "upCmdAccept",
            64'(upCmdAccept), 64'(modelAccept(upRespAccept)));
      expResp = (respQ.size() != 0) ? respQ[0].code : 2'd0;
      check(upResp === expResp, "R6", "upResp", 64'(upResp), 64'(expResp));
      if (respQ.size() != 0) begin
        check(upRespData === respQ[0].data, "R6", "upRespData",
              64'(upRespData), 64'(respQ[0].data));
        check(upRespLast === respQ[0].last, "R7", "upRespLast",
              64'(upRespLast), 64'(respQ[0].last));
      end
      if (prevValid && prevResp != 2'd0 && !prevRa)
        check(upResp === prevResp && upRespData === prevData && upRespLast === prevLast,
              "R8", "held response", {upRespLast, upResp, upRespData},
              {prevLast, prevResp, prevData});
      if (upResp != 2'd0 && upRespAccept) respCount++;
      if (upResp != 2'd0 && upRespAccept && upCmdAccept && upCmd != 3'd0) overlapCount++;
      if (dnCmd != 3'd0 && dnCmdAccept) dnLog.push_back(dnAddr);
      prevResp = upResp; prevData = upRespData; prevLast = upRespLast;
      prevRa = upRespAccept; prevValid = 1'b1;
    end
  end

  // ---------------- downstream slave ----------------
  int  slAccMode = 0;
  int  slDelMode = 0;
  bit  strayReq = 1'b0;
  bit  slPend = 1'b0;
  int  slWait = 0;
  logic [1:0]    slCode = '0;
  logic [DW-1:0] slData = '0;
  logic [15:0]   slLfsr = 16'hACE1;

  always @(negedge clk) begin
    int d;
    slLfsr = {slLfsr[14:0], slLfsr[15] ^ slLfsr[13] ^ slLfsr[12] ^ slLfsr[10]};
    if (!rstN) begin
      dnCmdAccept = 1'b0; dnResp = 2'd0; slPend = 1'b0;
    end else begin
      dnResp = 2'd0;
      if (strayReq) begin dnResp = 2'd1; dnRespData = 32'hDEAD_BEEF; end
      if (slPend) begin
        if (slWait == 0) begin
          dnResp = slCode; dnRespData = slData; slPend = 1'b0;
        end else slWait--;
      end
      dnCmdAccept = (slAccMode == 0) ? 1'b1 : slLfsr[0];
      if (dnCmdAccept && (dnCmd == 3'd2 || dnCmd == 3'd5)) begin
        slData = (dnCmd == 3'd2) ? (dnAddr ^ 32'h5A5A_0000) : 32'h0000_0077;
        slCode = (dnAddr[7:0] == 8'hEC) ? 2'd3 : 2'd1;
        d = (slDelMode == 0) ? 0 : int'(slLfsr[3:2]) % 3;
        if (d == 0 && dnResp == 2'd0) begin
          dnResp = slCode; dnRespData = slData;
        end else begin
          slPend = 1'b1; slWait = (d == 0) ? 0 : d - 1;
        end
      end
    end
  end

  // ---------------- upstream response acceptor ----------------
  int raMode = 0;
  logic [15:0] raLfsr = 16'h1D2B;
  always @(negedge clk) begin
    raLfsr = {raLfsr[14:0], raLfsr[15] ^ raLfsr[13] ^ raLfsr[12] ^ raLfsr[10]};
    case (raMode)
      0: upRespAccept = 1'b1;
      1: upRespAccept = raLfsr[5];
      default: upRespAccept = raLfsr[5] & raLfsr[6];
    endcase
  end

  // ---------------- master driver ----------------
  logic [AW-1:0] expLog[$];

  task automatic sendBeat(input logic [2:0] c, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [BW-1:0] be, input bit last);
    bit taken;
    taken = 1'b0;
    @(negedge clk);
    upCmd = c; upAddr = a; upData = d; upByteEn = be; upReqLast = last;
    while (!taken) begin
      #1;
      if (upCmdAccept) taken = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic burst(input logic [2:0] c, input logic [AW-1:0] base,
                       input int len, input int mode);
    logic [AW-1:0] a;
    logic [AW-1:0] win;
    win = AW'(len * 4);
    for (int i = 0; i < len; i++) begin
      case (mode)
        0: a = base + AW'(4 * i);
        1: a = (base & ~(win - 1)) | ((base + AW'(4 * i)) & (win - 1));
        default: a = base;
      endcase
      if (c != 3'd3) expLog.push_back(a);
      sendBeat(c, a, {base[15:0], 16'(i)}, BW'(4'hF >> (i % 3)), i == len - 1);
    end
    @(negedge clk);
    upCmd = 3'd0; upReqLast = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((fwdQ.size() + awaitQ.size() + respQ.size()) != 0 && n < 200) begin
      @(negedge clk); n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nBad++;
    $display("FAIL R4 watchdog expired act=%0d exp=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int rc;
    // R1: reset state
    #10;
    check(dnCmd === 3'd0, "R1", "dnCmd in reset", 64'(dnCmd), 0);
    check(upResp === 2'd0, "R1", "upResp in reset", 64'(upResp), 0);
    check(upRespLast === 1'b0, "R1", "upRespLast in reset", 64'(upRespLast), 0);
    check(upCmdAccept === 1'b1, "R1", "upCmdAccept in reset", 64'(upCmdAccept), 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R6 / R7: incrementing read burst, simple slave
    burst(3'd2, 32'h0000_0100, 4, 0);
    drain();

    // R3 / R5: wrapping posted-write burst, no upstream responses
    dnLog.delete(); expLog.delete();
    rc = respCount;
    slAccMode = 1;
    burst(3'd1, 32'h0000_0218, 4, 1);
    drain();
    check(respCount == rc, "R5", "responses after posted burst", 64'(respCount), 64'(rc));
    check(dnLog.size() == 4, "R3", "wrap beat count", 64'(dnLog.size()), 4);
    for (int i = 0; i < 4 && i < dnLog.size(); i++)
      check(dnLog[i] == expLog[i], "R3", "wrap address", 64'(dnLog[i]), 64'(expLog[i]));

    // R3: constant-address non-posted write burst with slave latency
    dnLog.delete(); expLog.delete();
    slDelMode = 1; raMode = 1;
    rc = respCount;
    burst(3'd5, 32'h0000_03EC, 3, 2);
    drain();
    check(dnLog.size() == 3, "R3", "stream beat count", 64'(dnLog.size()), 3);
    for (int i = 0; i < 3 && i < dnLog.size(); i++)
      check(dnLog[i] == 32'h0000_03EC, "R3", "stream address", 64'(dnLog[i]), 32'h3EC);
    check(respCount == rc + 3, "R6", "non-posted responses", 64'(respCount), 64'(rc + 3));

    // R2: unlisted command code is idle
    @(negedge clk);
    upCmd = 3'd3; upAddr = 32'h44;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      check(dnCmd === 3'd0, "R2", "bad code forwarded", 64'(dnCmd), 0);
    end
    upCmd = 3'd0;
    drain();

    // R10: stray downstream response while idle
    @(negedge clk); strayReq = 1'b1;
    @(negedge clk); strayReq = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #2;
      check(upResp === 2'd0, "R10", "stray response surfaced", 64'(upResp), 0);
      @(negedge clk);
    end

    // R9: back-to-back reads, zero-latency slave, always-accepting master
    slAccMode = 0; slDelMode = 0; raMode = 0;
    overlapCount = 0;
    burst(3'd2, 32'h0000_0400, 6, 0);
    drain();
    check(overlapCount > 0, "R9", "retire-and-take cycles", 64'(overlapCount), 1);

    // Mixed random traffic with back-pressure on both sides
    slAccMode = 1; slDelMode = 1; raMode = 2;
    for (int k = 0; k < 40; k++) begin
      logic [2:0] c;
      int sel;
      sel = $urandom_range(0, 2);
      c = (sel == 0) ? 3'd1 : (sel == 1) ? 3'd2 : 3'd5;
      burst(c, AW'($urandom_range(0, 255)) << 4, 1 << $urandom_range(0, 2),
            $urandom_range(0, 2));
    end
    drain();

    finishRun();
  end

endmodule